// File: doc/BRIEF.md
# Subroutine Call and Return Bus Sequencer

This block drives the memory bus for the six control-transfer instructions of a small 8-bit processor that has a 16-bit program counter and an 8-bit stack pointer: direct subroutine call, page call, table call, software break, plain return and return from interrupt. The instruction decoder raises `start` during the opcode fetch cycle with the instruction class, the opcode address, the current stack pointer, the status byte and, for the table call, a vector index. From the next cycle on, the sequencer owns the bus. Each cycle it either pushes, pops, reads an operand or vector byte, or spends an idle cycle.

Every instruction follows a fixed layout. All stack pushes come before the fetch of the target, and several idle cycles fill out the tail of the instruction. The stack is in page 0x01. A push writes at 0x0100+SP and then decrements SP. A pop first increments SP and then reads at the new 0x0100+SP. On the last cycle of the instruction, the sequencer pulses `done` and presents the new program counter, the final stack pointer and, after a return from interrupt, the restored status byte.

Top module: `call_return_seq`

## Requirements
- R1: While `rstN` is low, `busy`, `rdEn`, `wrEn`, `done` and `pswLoad` are 0, and `spOut` and `pcOut` are 0.
- R2: A `start` is accepted only while `busy` is 0 and `opClass` is one of 0 (call), 1 (page call), 2 (table call), 3 (break), 4 (return) or 5 (return from interrupt). A `start` with class 6 or 7, or one raised while `busy` is 1 (including the `done` cycle), has no effect: the bus stays quiet and `spOut`/`pcOut` keep their values.
- R3: A push cycle writes at address {0x01, SP} and leaves SP one lower. A pop cycle reads at {0x01, SP+1} and leaves SP one higher. Both wrap modulo 256 inside the stack page.
- R4: Call takes 7 cycles after the opcode: push return high, push return low, idle, read target low at opcode address+1, read target high at +2, idle, idle.
- R5: Page call takes 5 cycles after the opcode: push return high, push return low, read an offset byte at opcode address+1, then read at 0xFF00+offset and 0xFF01+offset. The new PC is 0xFF00+offset.
- R6: Table call with index n (0..15) takes 7 cycles after the opcode: push high, push low, idle, read new PC low at 0xFFDE-2n, read high at 0xFFDF-2n, idle, idle.
- R7: Break takes 7 cycles after the opcode: push return high, return low, then `pswIn` on three consecutive push cycles; read new PC low at 0xFFDE and high at 0xFFDF; idle, idle.
- R8: Return takes 4 cycles after the opcode: pop PC low, pop PC high, idle, idle.
- R9: Return from interrupt takes 5 cycles after the opcode: pop status, pop PC low, pop PC high, idle, idle. `pswLoad` is 1 only in its `done` cycle, with the popped status on `pswOut`.
- R10: The pushed return address is the opcode address plus 3 (call), 2 (page call) or 1 (table call, break), modulo 65536. Operand fetch addresses also wrap modulo 65536.
- R11: `done` is 1 for exactly the last cycle of an instruction, and `busy` falls right after it. From `done` until the next accepted start, `pcOut` and `spOut` hold the new PC and the final SP.
- R12: In an idle cycle, `rdEn` and `wrEn` are 0 and `busAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opcode-cycle request to begin an instruction |
| opClass | input | 3 | Instruction class, encoding as in R2 |
| pcIn | input | 16 | Address of the opcode byte |
| spIn | input | 8 | Stack pointer at start |
| pswIn | input | 8 | Status byte to push on break |
| tableIdx | input | 4 | Table-call vector index |
| rdData | input | 8 | Read data returned in the cycle of `rdEn` |
| busAddr | output | 16 | Bus address |
| rdEn | output | 1 | Read strobe |
| wrEn | output | 1 | Write strobe |
| wrData | output | 8 | Write data |
| spOut | output | 8 | Running stack pointer |
| pcOut | output | 16 | New program counter, valid from `done` |
| pswOut | output | 8 | Status byte restored by return from interrupt |
| pswLoad | output | 1 | Status restore pulse |
| done | output | 1 | Last cycle of the instruction |
| busy | output | 1 | Instruction in progress |

## Verification
The bench uses the default parameters: the stack in page 0x01, a break vector at 0xFFDE, the page-call base at 0xFF00 and a 4-bit table index. These values make the extreme table index, which lands on 0xFFC0, easy to exercise. They also bring stack wrap within reach: a break started with SP at 0x01 pushes across 0x00 to 0xFF, and the return from interrupt that follows pops the same bytes back across the boundary. A call at 0xFFFE wraps both the operand fetch and the return address, and a `start` held high runs back to back against the `done` cycle.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_PCALL = 3'd1,
    OP_TCALL = 3'd2,
    OP_BRK   = 3'd3,
    OP_RET   = 3'd4,
    OP_RETI  = 3'd5
  } opClass_e;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_PUSH,
    BUS_POP,
    BUS_READ
  } busOp_e;

  typedef enum logic [1:0] {
    SRC_RETHI,
    SRC_RETLO,
    SRC_PSW
  } pushSrc_e;

  typedef enum logic [1:0] {
    RA_NEXT1,
    RA_NEXT2,
    RA_VEC0,
    RA_VEC1
  } rdAddr_e;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_PCLO,
    LD_PCHI,
    LD_PSW,
    LD_PAGE
  } load_e;

  typedef struct packed {
    logic     capture;
    busOp_e   busOp;
    pushSrc_e pushSrc;
    rdAddr_e  rdAddr;
    load_e    load;
    logic     done;
  } ctl_t;

  localparam int unsigned NUM_CLASSES = 6;

endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int unsigned CLASS_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CLASS_W-1:0] opClass,
  output ctl_t               ctl,
  output logic               busy
);

  localparam int unsigned MAX_STEP = 6;
  localparam int unsigned STEP_W   = $clog2(MAX_STEP + 1);

  logic              active;
  opClass_e          op;
  logic [STEP_W-1:0] step;
  logic              classOk;

  assign classOk = (opClass < CLASS_W'(NUM_CLASSES));
  assign busy    = active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      op     <= OP_CALL;
      step   <= '0;
    end else if (ctl.capture) begin
      active <= 1'b1;
      op     <= opClass_e'(opClass);
      step   <= '0;
    end else if (active) begin
      if (ctl.done) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.busOp   = BUS_IDLE;
    ctl.pushSrc = SRC_RETHI;
    ctl.rdAddr  = RA_NEXT1;
    ctl.load    = LD_NONE;
    ctl.capture = start && !active && classOk;
    if (active) begin
      unique case (op)
        OP_CALL, OP_TCALL, OP_BRK: begin
          unique case (step)
            3'd0: ctl.busOp = BUS_PUSH;
            3'd1: begin ctl.busOp = BUS_PUSH; ctl.pushSrc = SRC_RETLO; end
            3'd2: if (op == OP_BRK) begin
                    ctl.busOp = BUS_PUSH; ctl.pushSrc = SRC_PSW;
                  end
            3'd3: begin
                    ctl.busOp  = BUS_READ;
                    ctl.rdAddr = (op == OP_CALL) ? RA_NEXT1 : RA_VEC0;
                    ctl.load   = LD_PCLO;
                  end
            3'd4: begin
                    ctl.busOp  = BUS_READ;
                    ctl.rdAddr = (op == OP_CALL) ? RA_NEXT2 : RA_VEC1;
                    ctl.load   = LD_PCHI;
                  end
            3'd6: ctl.done = 1'b1;
            default: ;
          endcase
        end
        OP_PCALL: begin
          unique case (step)
            3'd0: ctl.busOp = BUS_PUSH;
            3'd1: begin ctl.busOp = BUS_PUSH; ctl.pushSrc = SRC_RETLO; end
            3'd2: begin ctl.busOp = BUS_READ; ctl.rdAddr = RA_NEXT1; ctl.load = LD_PAGE; end
            3'd3: begin ctl.busOp = BUS_READ; ctl.rdAddr = RA_VEC0; end
            3'd4: begin ctl.busOp = BUS_READ; ctl.rdAddr = RA_VEC1; ctl.done = 1'b1; end
            default: ;
          endcase
        end
        OP_RET: begin
          unique case (step)
            3'd0: begin ctl.busOp = BUS_POP; ctl.load = LD_PCLO; end
            3'd1: begin ctl.busOp = BUS_POP; ctl.load = LD_PCHI; end
            3'd3: ctl.done = 1'b1;
            default: ;
          endcase
        end
        OP_RETI: begin
          unique case (step)
            3'd0: begin ctl.busOp = BUS_POP; ctl.load = LD_PSW; end
            3'd1: begin ctl.busOp = BUS_POP; ctl.load = LD_PCLO; end
            3'd2: begin ctl.busOp = BUS_POP; ctl.load = LD_PCHI; end
            3'd4: ctl.done = 1'b1;
            default: ;
          endcase
        end
        default: ctl.done = 1'b1;
      endcase
    end
  end

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !busy) else $error("done not followed by idle"); // R11

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> step <= STEP_W'(MAX_STEP)) else $error("step overrun"); // R11

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (active && !ctl.done) |=> active) else $error("instruction cut short"); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (ctl.busOp == BUS_IDLE && !ctl.done)) else $error("bus activity while idle"); // R2

endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned CLASS_W    = 3,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  PAGE_HI    = 8'hFF,
  parameter logic [15:0] BRK_VEC    = 16'hFFDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [CLASS_W-1:0]  opClass,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   pswIn,
  input  logic [IDX_W-1:0]    tableIdx,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] busAddr,
  output logic                rdEn,
  output logic                wrEn,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   spOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   pswOut,
  output logic                pswLoad
);

  localparam int unsigned PC_W = 2 * DATA_W;

  logic [DATA_W-1:0] sp;
  logic [PC_W-1:0]   opAddr;
  logic [PC_W-1:0]   retAddr;
  logic [PC_W-1:0]   vecAddr;
  logic [PC_W-1:0]   newPc;
  logic [DATA_W-1:0] pswSave;
  logic [DATA_W-1:0] pswPop;
  logic              pswHeld;

  function automatic logic [PC_W-1:0] instLen(input logic [CLASS_W-1:0] cls);
    unique case (opClass_e'(cls))
      OP_CALL:  return PC_W'(3);
      OP_PCALL: return PC_W'(2);
      default:  return PC_W'(1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= '0;
      opAddr  <= '0;
      retAddr <= '0;
      vecAddr <= '0;
      newPc   <= '0;
      pswSave <= '0;
      pswPop  <= '0;
      pswHeld <= 1'b0;
    end else if (ctl.capture) begin
      sp      <= spIn;
      opAddr  <= pcIn;
      retAddr <= pcIn + instLen(opClass);
      pswSave <= pswIn;
      pswHeld <= 1'b0;
      vecAddr <= (opClass_e'(opClass) == OP_TCALL)
                 ? BRK_VEC - (PC_W'(tableIdx) << 1) : BRK_VEC;
    end else begin
      unique case (ctl.busOp)
        BUS_PUSH: sp <= sp - 1'b1;
        BUS_POP:  sp <= sp + 1'b1;
        default:  ;
      endcase
      unique case (ctl.load)
        LD_PCLO: newPc[DATA_W-1:0]    <= rdData;
        LD_PCHI: newPc[PC_W-1:DATA_W] <= rdData;
        LD_PSW:  begin pswPop <= rdData; pswHeld <= 1'b1; end
        LD_PAGE: begin
                   newPc   <= {PAGE_HI, rdData};
                   vecAddr <= {PAGE_HI, rdData};
                 end
        default: ;
      endcase
    end
  end

  always_comb begin
    busAddr = '0;
    wrData  = '0;
    unique case (ctl.busOp)
      BUS_PUSH: begin
        busAddr = {STACK_PAGE, sp};
        unique case (ctl.pushSrc)
          SRC_RETHI: wrData = retAddr[PC_W-1:DATA_W];
          SRC_RETLO: wrData = retAddr[DATA_W-1:0];
          default:   wrData = pswSave;
        endcase
      end
      BUS_POP: busAddr = {STACK_PAGE, sp + 1'b1};
      BUS_READ: begin
        unique case (ctl.rdAddr)
          RA_NEXT1: busAddr = opAddr + PC_W'(1);
          RA_NEXT2: busAddr = opAddr + PC_W'(2);
          RA_VEC0:  busAddr = vecAddr;
          default:  busAddr = vecAddr + PC_W'(1);
        endcase
      end
      default: ;
    endcase
  end

  assign rdEn    = (ctl.busOp == BUS_POP) || (ctl.busOp == BUS_READ);
  assign wrEn    = (ctl.busOp == BUS_PUSH);
  assign spOut   = sp;
  assign pcOut   = newPc;
  assign pswOut  = pswPop;
  assign pswLoad = ctl.done && pswHeld;

  AST_POP_INC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busOp == BUS_POP) |=> spOut == $past(busAddr[DATA_W-1:0]))
    else $error("pop left wrong stack pointer"); // R3

  AST_POP_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busOp == BUS_POP) |-> busAddr[PC_W-1:DATA_W] == STACK_PAGE)
    else $error("pop outside stack page"); // R3

  AST_PSW_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pswLoad |=> !pswLoad) else $error("status restore longer than a cycle"); // R9

endmodule

// File: rtl/call_return_seq.sv
module call_return_seq
  import crs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IDX_W      = 4,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  PAGE_HI    = 8'hFF,
  parameter logic [15:0] BRK_VEC    = 16'hFFDE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opClass,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   pswIn,
  input  logic [IDX_W-1:0]    tableIdx,
  input  logic [DATA_W-1:0]   rdData,
  output logic [2*DATA_W-1:0] busAddr,
  output logic                rdEn,
  output logic                wrEn,
  output logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   spOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   pswOut,
  output logic                pswLoad,
  output logic                done,
  output logic                busy
);

  ctl_t ctl;

  crs_ctrl #(.CLASS_W(3)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opClass (opClass),
    .ctl     (ctl),
    .busy    (busy)
  );

  crs_datapath #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .CLASS_W    (3),
    .STACK_PAGE (STACK_PAGE),
    .PAGE_HI    (PAGE_HI),
    .BRK_VEC    (BRK_VEC)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opClass  (opClass),
    .pcIn     (pcIn),
    .spIn     (spIn),
    .pswIn    (pswIn),
    .tableIdx (tableIdx),
    .rdData   (rdData),
    .busAddr  (busAddr),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .spOut    (spOut),
    .pcOut    (pcOut),
    .pswOut   (pswOut),
    .pswLoad  (pswLoad)
  );

  assign done = ctl.done;

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> spOut == $past(busAddr[DATA_W-1:0]) - 1'b1)
    else $error("push left wrong stack pointer"); // R3

  AST_WR_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busAddr[2*DATA_W-1:DATA_W] == STACK_PAGE)
    else $error("write outside stack page"); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn)) else $error("read and write together"); // R12

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy) else $error("done outside instruction"); // R11

endmodule

// File: tb/sim_call_return_seq.sv
module sim_call_return_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opClass = '0;
  logic [15:0] pcIn = '0;
  logic [7:0]  spIn = '0;
  logic [7:0]  pswIn = '0;
  logic [3:0]  tableIdx = '0;
  logic [7:0]  rdData = '0;
  logic [15:0] busAddr;
  logic        rdEn, wrEn, pswLoad, done, busy;
  logic [7:0]  wrData, spOut, pswOut;
  logic [15:0] pcOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  call_return_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass), .pcIn(pcIn),
    .spIn(spIn), .pswIn(pswIn), .tableIdx(tableIdx), .rdData(rdData),
    .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .spOut(spOut), .pcOut(pcOut), .pswOut(pswOut), .pswLoad(pswLoad),
    .done(done), .busy(busy)
  );

  typedef struct {
    logic [15:0] addr;
    bit          rd;
    bit          wr;
    logic [7:0]  wd;
    bit          dn;
    logic [7:0]  sp;
    logic [15:0] pc;
    bit          pl;
    logic [7:0]  psw;
    string       tag;
    string       wtag;
  } rec_t;

  rec_t        expQ[$];
  logic [7:0]  mem[int];
  logic [7:0]  mSp;
  logic [15:0] lastPc = '0;
  logic [7:0]  lastSp = '0;

  function automatic logic [7:0] memRd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void addRec(input logic [15:0] a, input bit rd, input bit wr,
                                 input logic [7:0] wd, input string tag, input string wtag);
    rec_t t;
    t.addr = a; t.rd = rd; t.wr = wr; t.wd = wd; t.dn = 0; t.sp = mSp;
    t.pc = '0; t.pl = 0; t.psw = '0; t.tag = tag; t.wtag = wtag;
    expQ.push_back(t);
  endfunction

  function automatic void mPush(input logic [7:0] v, input string tag);
    addRec({8'h01, mSp}, 0, 1, v, "R3", tag);
    mSp = mSp - 8'd1;
  endfunction

  function automatic logic [7:0] mPop(input string tag);
    logic [7:0] a;
    a = mSp + 8'd1;
    addRec({8'h01, a}, 1, 0, '0, "R3", tag);
    mSp = a;
    return memRd({8'h01, a});
  endfunction

  function automatic logic [7:0] mRead(input logic [15:0] a, input string tag);
    addRec(a, 1, 0, '0, tag, tag);
    return memRd(a);
  endfunction

  function automatic void mIdle(input string tag);
    addRec('0, 0, 0, '0, tag, tag);
  endfunction

  function automatic void buildModel(input int op, input logic [15:0] pc,
                                     input logic [7:0] sp, input logic [7:0] psw,
                                     input logic [3:0] idx);
    logic [15:0] ret, npc, vec;
    logic [7:0]  lo, hi, ofs, pp;
    string       tg;
    rec_t        t;
    bit          pl;
    mSp = sp; pl = 0; pp = '0; npc = '0;
    ret = pc + ((op == 0) ? 16'd3 : (op == 1) ? 16'd2 : 16'd1);
    case (op)
      0, 2, 3: begin
        tg = (op == 0) ? "R4" : (op == 2) ? "R6" : "R7";
        mPush(ret[15:8], "R10");
        mPush(ret[7:0], "R10");
        if (op == 3) mPush(psw, "R7"); else mIdle("R12");
        vec = (op == 2) ? 16'hFFDE - {11'd0, idx, 1'b0} : 16'hFFDE;
        lo = mRead((op == 0) ? pc + 16'd1 : vec, (op == 0) ? "R10" : tg);
        hi = mRead((op == 0) ? pc + 16'd2 : vec + 16'd1, (op == 0) ? "R10" : tg);
        mIdle("R12");
        mIdle("R12");
        npc = {hi, lo};
      end
      1: begin
        mPush(ret[15:8], "R10");
        mPush(ret[7:0], "R10");
        ofs = mRead(pc + 16'd1, "R5");
        lo = mRead({8'hFF, ofs}, "R5");
        hi = mRead({8'hFF, ofs} + 16'd1, "R5");
        npc = {8'hFF, ofs};
      end
      4: begin
        lo = mPop("R8");
        hi = mPop("R8");
        mIdle("R12");
        mIdle("R12");
        npc = {hi, lo};
      end
      default: begin
        pp = mPop("R9");
        lo = mPop("R9");
        hi = mPop("R9");
        mIdle("R12");
        mIdle("R12");
        npc = {hi, lo};
        pl = 1;
      end
    endcase
    t = expQ.pop_back();
    t.dn = 1; t.pc = npc; t.pl = pl; t.psw = pp;
    expQ.push_back(t);
  endfunction

  always @(posedge clk) begin
    if (rstN && wrEn) mem[int'(busAddr)] = wrData;
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expQ.size() == 0) begin
        check("R2", "busy idle", busy, 0);
        check("R2", "rdEn idle", rdEn, 0);
        check("R2", "wrEn idle", wrEn, 0);
        check("R2", "done idle", done, 0);
        check("R2", "pswLoad idle", pswLoad, 0);
        check("R11", "spOut hold", spOut, lastSp);
        check("R11", "pcOut hold", pcOut, lastPc);
        if (start && opClass < 3'd6)
          buildModel(int'(opClass), pcIn, spIn, pswIn, tableIdx);
      end else begin
        rec_t e;
        e = expQ.pop_front();
        check(e.tag, "busy", busy, 1);
        check(e.tag, "rdEn", rdEn, e.rd);
        check(e.tag, "wrEn", wrEn, e.wr);
        check(e.tag, "busAddr", busAddr, e.addr);
        if (e.wr) check(e.wtag, "wrData", wrData, e.wd);
        check("R3", "spOut", spOut, e.sp);
        check("R11", "done", done, e.dn);
        check("R9", "pswLoad", pswLoad, e.pl);
        if (e.pl) check("R9", "pswOut", pswOut, e.psw);
        if (e.dn) begin
          check("R11", "pcOut at done", pcOut, e.pc);
          lastPc = e.pc;
          lastSp = e.sp;
        end
      end
      rdData = rdEn ? memRd(busAddr) : 8'h00;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [15:0] pc,
                       input logic [7:0] sp, input logic [7:0] psw,
                       input logic [3:0] idx, input int gap);
    @(posedge clk); #1;
    start = 1'b1; opClass = op; pcIn = pc; spIn = sp; pswIn = psw; tableIdx = idx;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "busy reset", busy, 0);
    check("R1", "rdEn reset", rdEn, 0);
    check("R1", "wrEn reset", wrEn, 0);
    check("R1", "done reset", done, 0);
    check("R1", "pswLoad reset", pswLoad, 0);
    check("R1", "spOut reset", spOut, 0);
    check("R1", "pcOut reset", pcOut, 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    issue(3'd0, 16'h1234, 8'hF0, 8'h00, 4'd0, 9);   // R4 call
    issue(3'd4, 16'h4000, 8'hEE, 8'h00, 4'd0, 9);   // R8 return to 0x1237
    issue(3'd1, 16'h2000, 8'h80, 8'h00, 4'd0, 9);   // R5 page call
    issue(3'd2, 16'h3000, 8'h70, 8'h00, 4'd0, 9);   // R6 index 0
    issue(3'd2, 16'h3001, 8'h70, 8'h00, 4'd15, 9);  // R6 index 15 -> 0xFFC0
    issue(3'd3, 16'h5555, 8'h01, 8'hA5, 4'd0, 9);   // R7 break with stack wrap
    issue(3'd5, 16'h6000, 8'hFE, 8'h00, 4'd0, 9);   // R9 return from interrupt
    issue(3'd6, 16'h7000, 8'h40, 8'h00, 4'd0, 4);   // R2 class 6 ignored
    issue(3'd7, 16'h7000, 8'h40, 8'h00, 4'd0, 4);   // R2 class 7 ignored
    issue(3'd0, 16'hFFFE, 8'h90, 8'h00, 4'd0, 1);   // R10 wrap
    issue(3'd4, 16'h1111, 8'h20, 8'h00, 4'd0, 9);   // R2 start while busy
    // back-to-back starts held high against the done cycle
    @(posedge clk); #1;
    start = 1'b1; opClass = 3'd4; pcIn = 16'h0800; spIn = 8'h8D; tableIdx = '0;
    repeat (12) @(posedge clk);
    #1 start = 1'b0;
    repeat (10) @(posedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule